// File: doc/BRIEF.md
# Microprogrammed Ethernet Frame Classifier

This block sorts received Ethernet frames into classes while the frame is still arriving, 16 bits at a time. A short microprogram sits in a writable instruction memory of 64 entries. Each arriving frame word runs exactly one instruction: the word with index k in the frame, counted from 0 at start of frame, executes the instruction at address k. There is no stall path, so an instruction may only look at words that have already arrived. The word arriving in the same cycle counts as arrived.

The program works on a file of 32 one-bit flags. It can compare a frame word against a constant under a nibble mask, test one bit of a word, and combine flags with two- or three-operand logic. When the program reaches its terminate instruction, or when the frame ends first, the block emits an 8-bit multi-hot class vector and a drop flag, marked by a one-cycle valid strobe. Software loads the microcode in two steps. It first writes the low 12 bits of an instruction into a holding register. It then writes the upper 24 bits with an address and a commit strobe, which stores the whole 36-bit word. An enable input gates classification.

Top module: `cls_frame_classifier`

## Requirements
- R1: The flag file has 32 one-bit registers. Register 0 always reads 0 and ignores writes. On a result, the drop flag is register 23 and class bit c (0 to 7) is register 24+c.
- R2: The instruction at address k runs in the cycle that frame word k is accepted. Cycles with `word_valid` low do not advance the program. A test whose word offset equals its own address uses the word arriving in that cycle.
- R3: Instruction bits [35:34]=0 with bit 33=0 is a masked compare. It computes t = ((word[off] & M) == V), where off=[12:7], V=[28:13], and M enables nibble n (word bits 4n+3..4n) when bit 29+n is set. It then writes Rd = OP(t, Rd), where Rd=[6:3] addresses registers 0 to 15.
- R4: Bits [35:34]=0 with bit 33=1 is a bit test. It computes t = bit [32:29] of word[off] and writes Rd = OP(t, Rd), with off and Rd placed as in R3.
- R5: The operation field [2:0] gives OP(a,b): 0 gives a (move), 1 gives a AND b, 2 gives a OR b, 3 gives a XOR b, 4 gives NOT a. Codes 5 to 7 act as move.
- R6: Bits [35:34]=1 is two-operand logic, Rd = OP(Ra, Rb). Bits [35:34]=2 is three-operand logic, Rd = OP2(OP(Ra, Rb), Rc). Here Rd=[7:3], Ra=[12:8], Rb=[17:13], Rc=[22:18] and OP2=[25:23].
- R7: Bits [35:34]=3 terminates the program. It changes no flag, and the result is valid in the cycle after that word. Later words of the same frame, including its end, produce no further result.
- R8: If a frame ends before the program terminates, the result reflects the flags after the last word's instruction and is valid in the cycle after that word. Words beyond address 63 run nothing.
- R9: Start of frame clears every flag before instruction 0 runs. A new start of frame in the middle of a frame abandons the old frame without a result.
- R10: A write of the low holding register stores 12 bits. A high write with commit stores {high 24 bits, held low 12 bits} at the given address. A high write without commit leaves the memory unchanged.
- R11: A frame whose start word arrives while `cfg_enable` is low is ignored completely, and so are words outside any frame.
- R12: After reset, `res_valid`, `res_class` and `res_drop` are 0, the low holding register is 0, and every instruction memory entry is 0 (a compare into register 0, which has no effect).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_valid | input | 1 | Frame word present this cycle |
| word_sof | input | 1 | This word is word 0 of a frame |
| word_eof | input | 1 | This word is the last of the frame |
| word_data | input | 16 | Frame word, first byte in the upper half |
| cfg_enable | input | 1 | Classification enable, sampled at start of frame |
| ld_lo_we | input | 1 | Write strobe for the low holding register |
| ld_lo_bits | input | 12 | Low 12 instruction bits |
| ld_hi_we | input | 1 | Write strobe for the high control register |
| ld_commit | input | 1 | Commit bit of the high control register |
| ld_addr | input | 6 | Instruction address to store |
| ld_hi_bits | input | 24 | Upper 24 instruction bits |
| res_valid | output | 1 | One-cycle result strobe |
| res_class | output | 8 | Multi-hot class vector |
| res_drop | output | 1 | Drop indication |

## Verification
The bench aims at where the result is taken. A frame ends before its terminate instruction, a terminate lands on the last word, and a terminate is followed by extra words. A design that counted the frame end twice would pulse twice, and one that missed the end-of-frame path would never report short frames. Frames with idle gaps, a compare on the word arriving in the same cycle, and a frame of more than 64 words check the program counter: an off-by-one shows up as the wrong class bits. Back-to-back frames and a restart in mid-frame catch flags that are not cleared at start of frame. A high write without commit catches a loader that stores on any high write.

// File: rtl/cls_pkg.sv
// Shared constants, encodings and the one-bit operation for the frame
// classifier. Assumes 16-bit frame words and a 36-bit instruction word.
package cls_pkg;
    localparam int WORD_W      = 16;
    localparam int IMEM_DEPTH  = 64;
    localparam int PC_W        = $clog2(IMEM_DEPTH);
    localparam int NUM_REGS    = 32;
    localparam int REG_W       = $clog2(NUM_REGS);
    localparam int NUM_CLASSES = 8;
    localparam int DROP_REG    = 23;
    localparam int CLASS_BASE  = 24;
    localparam int INS_W       = 36;
    localparam int LO_W        = 12;
    localparam int HI_W        = INS_W - LO_W;
    localparam int NIB_N       = WORD_W / 4;

    typedef logic [INS_W-1:0] instr_t;

    typedef enum logic [1:0] {
        MODE_TEST = 2'd0,
        MODE_LOG2 = 2'd1,
        MODE_LOG3 = 2'd2,
        MODE_FIN  = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        OP_MOV = 3'd0,
        OP_AND = 3'd1,
        OP_OR  = 3'd2,
        OP_XOR = 3'd3,
        OP_NOT = 3'd4
    } op_e;

    // Combines two flags under a 3-bit operation code; unknown codes move a.
    function automatic logic apply_op(input logic [2:0] op, input logic a, input logic b);
        case (op)
            OP_AND:  return a & b;
            OP_OR:   return a | b;
            OP_XOR:  return a ^ b;
            OP_NOT:  return ~a;
            default: return a;
        endcase
    endfunction
endpackage

// File: rtl/cls_ucode_store.sv
// Instruction memory with a two-step loader: a 12-bit low holding register,
// then a high write that commits {high, low} at an address when its commit
// bit is set. Assumes one combinational read port, addressed by the
// program counter.
module cls_ucode_store
    import cls_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lo_we,
    input  logic [LO_W-1:0] lo_bits,
    input  logic            hi_we,
    input  logic            commit,
    input  logic [PC_W-1:0] wr_addr,
    input  logic [HI_W-1:0] hi_bits,
    input  logic [PC_W-1:0] rd_addr,
    output instr_t          rd_instr
);
    logic [LO_W-1:0] lo_q;
    instr_t          mem_q [IMEM_DEPTH];

    // Holding register and memory update; reset leaves no-op instructions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            for (int i = 0; i < IMEM_DEPTH; i++) mem_q[i] <= '0;
        end else begin
            if (lo_we) lo_q <= lo_bits;
            if (hi_we && commit) mem_q[wr_addr] <= {hi_bits, lo_q};
        end
    end

    // Instruction fetch for the executing word.
    assign rd_instr = mem_q[rd_addr];

    a_r10_commit_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_we && commit) |=> (mem_q[$past(wr_addr)] == {$past(hi_bits), $past(lo_q)}));
endmodule

// File: rtl/cls_word_window.sv
// Keeps every word of the current frame by its index so that tests can
// look back. A test naming the index being written this cycle gets the
// arriving word. Assumes offsets never exceed the current index.
module cls_word_window
    import cls_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PC_W-1:0]   wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [PC_W-1:0]   rd_idx,
    output logic [WORD_W-1:0] rd_word
);
    logic [WORD_W-1:0] win_q [IMEM_DEPTH];

    // Store each executed word at its frame index.
    always_ff @(posedge clk) begin
        if (wr_en) win_q[wr_idx] <= wr_data;
    end

    // Operand select with bypass of the arriving word.
    assign rd_word = (rd_idx == wr_idx) ? wr_data : win_q[rd_idx];

    a_r2_word_kept: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (win_q[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/cls_exec.sv
// Decodes one instruction and computes the next flag file. It is purely
// combinational and assumes the operand word is already selected by the
// offset field it exports.
module cls_exec
    import cls_pkg::*;
(
    input  instr_t              instr,
    input  logic [NUM_REGS-1:0] rf_in,
    input  logic [WORD_W-1:0]   opnd,
    output logic [PC_W-1:0]     word_sel,
    output logic [NUM_REGS-1:0] rf_out,
    output logic                is_fin
);
    logic [WORD_W-1:0] nib_mask;
    logic [REG_W-1:0]  wr_addr, ra, rb, rc;
    logic              wr_en, bit_v, tst, ab;
    mode_e             mode;

    // Expand the per-nibble enables into a bit mask.
    for (genvar n = 0; n < NIB_N; n++) begin : g_nib
        assign nib_mask[4*n +: 4] = {4{instr[29+n]}};
    end

    assign word_sel = instr[12:7];
    assign mode     = mode_e'(instr[35:34]);
    assign ra       = instr[12:8];
    assign rb       = instr[17:13];
    assign rc       = instr[22:18];

    // Per-mode evaluation and single-flag write.
    always_comb begin
        rf_out  = rf_in;
        wr_en   = 1'b0;
        wr_addr = '0;
        bit_v   = 1'b0;
        tst     = 1'b0;
        ab      = 1'b0;
        is_fin  = 1'b0;
        case (mode)
            MODE_TEST: begin
                tst     = instr[33] ? opnd[instr[32:29]]
                                    : ((opnd & nib_mask) == instr[28:13]);
                wr_addr = {1'b0, instr[6:3]};
                bit_v   = apply_op(instr[2:0], tst, rf_in[wr_addr]);
                wr_en   = 1'b1;
            end
            MODE_LOG2: begin
                wr_addr = instr[7:3];
                bit_v   = apply_op(instr[2:0], rf_in[ra], rf_in[rb]);
                wr_en   = 1'b1;
            end
            MODE_LOG3: begin
                wr_addr = instr[7:3];
                ab      = apply_op(instr[2:0], rf_in[ra], rf_in[rb]);
                bit_v   = apply_op(instr[25:23], ab, rf_in[rc]);
                wr_en   = 1'b1;
            end
            default: is_fin = 1'b1;
        endcase
        if (wr_en && wr_addr != '0) rf_out[wr_addr] = bit_v;
    end

    // Checks on the decoded update.
    always_comb begin
        if (is_fin) a_r7_fin_keeps_regs: assert (rf_out == rf_in);
        a_r1_reg0_untouched: assert (rf_out[0] == rf_in[0]);
    end
endmodule

// File: rtl/cls_frame_classifier.sv
// Top of the frame classifier. It tracks the frame, steps the program
// counter once per accepted word, holds the flag file and captures the
// result. Assumes at most one word per cycle, with no back-pressure.
module cls_frame_classifier
    import cls_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   word_valid,
    input  logic                   word_sof,
    input  logic                   word_eof,
    input  logic [WORD_W-1:0]      word_data,
    input  logic                   cfg_enable,
    input  logic                   ld_lo_we,
    input  logic [LO_W-1:0]        ld_lo_bits,
    input  logic                   ld_hi_we,
    input  logic                   ld_commit,
    input  logic [PC_W-1:0]        ld_addr,
    input  logic [HI_W-1:0]        ld_hi_bits,
    output logic                   res_valid,
    output logic [NUM_CLASSES-1:0] res_class,
    output logic                   res_drop
);
    logic                frm_active_q, done_q;
    logic [PC_W:0]       pc_q, pc_eff, pc_inc;
    logic [NUM_REGS-1:0] rf_q, rf_cur, rf_nxt, rf_res;
    logic                acc, done_eff, run, fin_hit, is_fin, emit;
    logic [PC_W-1:0]     word_sel;
    logic [WORD_W-1:0]   opnd;
    instr_t              instr;

    // Word acceptance, restart handling and result condition.
    always_comb begin
        acc      = word_valid && (word_sof ? cfg_enable : frm_active_q);
        done_eff = word_sof ? 1'b0 : done_q;
        pc_eff   = word_sof ? '0 : pc_q;
        run      = acc && !done_eff && !pc_eff[PC_W];
        rf_cur   = word_sof ? '0 : rf_q;
        rf_res   = run ? rf_nxt : rf_cur;
        fin_hit  = run && is_fin;
        pc_inc   = pc_eff[PC_W] ? pc_eff : pc_eff + 1'b1;
        emit     = acc && (fin_hit || (word_eof && !done_eff));
    end

    cls_ucode_store i_store (
        .clk(clk), .rst_n(rst_n),
        .lo_we(ld_lo_we), .lo_bits(ld_lo_bits),
        .hi_we(ld_hi_we), .commit(ld_commit),
        .wr_addr(ld_addr), .hi_bits(ld_hi_bits),
        .rd_addr(pc_eff[PC_W-1:0]), .rd_instr(instr)
    );

    cls_word_window i_window (
        .clk(clk), .rst_n(rst_n),
        .wr_en(run), .wr_idx(pc_eff[PC_W-1:0]), .wr_data(word_data),
        .rd_idx(word_sel), .rd_word(opnd)
    );

    cls_exec i_exec (
        .instr(instr), .rf_in(rf_cur), .opnd(opnd),
        .word_sel(word_sel), .rf_out(rf_nxt), .is_fin(is_fin)
    );

    // Frame tracking, program counter and flag file.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frm_active_q <= 1'b0;
            done_q       <= 1'b0;
            pc_q         <= '0;
            rf_q         <= '0;
        end else begin
            if (word_valid && word_sof) frm_active_q <= cfg_enable && !word_eof;
            else if (acc && word_eof)   frm_active_q <= 1'b0;
            if (acc) begin
                pc_q   <= pc_inc;
                done_q <= done_eff || fin_hit;
                rf_q   <= rf_res;
            end
        end
    end

    // Result capture with a one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_class <= '0;
            res_drop  <= 1'b0;
        end else begin
            res_valid <= emit;
            if (emit) begin
                res_class <= rf_res[CLASS_BASE +: NUM_CLASSES];
                res_drop  <= rf_res[DROP_REG];
            end
        end
    end

    a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !word_sof && !pc_q[PC_W]) |=> (pc_q == $past(pc_q) + 1'b1));
    a_r9_sof_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && word_sof && cfg_enable && !word_eof) |=> (pc_q == 1 && frm_active_q));
    a_r8_result_follows_word: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(word_valid));
    a_r11_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && word_sof && !cfg_enable) |=> !res_valid);
endmodule

// File: tb/test_cls_frame_classifier.sv
module test_cls_frame_classifier;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_valid = 1'b0, word_sof = 1'b0, word_eof = 1'b0;
    logic [15:0] word_data = '0;
    logic        cfg_enable = 1'b0;
    logic        ld_lo_we = 1'b0, ld_hi_we = 1'b0, ld_commit = 1'b0;
    logic [11:0] ld_lo_bits = '0;
    logic [5:0]  ld_addr = '0;
    logic [23:0] ld_hi_bits = '0;
    logic        res_valid, res_drop;
    logic [7:0]  res_class;

    cls_frame_classifier i_cls_frame_classifier (
        .clk(clk), .rst_n(rst_n),
        .word_valid(word_valid), .word_sof(word_sof), .word_eof(word_eof),
        .word_data(word_data), .cfg_enable(cfg_enable),
        .ld_lo_we(ld_lo_we), .ld_lo_bits(ld_lo_bits),
        .ld_hi_we(ld_hi_we), .ld_commit(ld_commit),
        .ld_addr(ld_addr), .ld_hi_bits(ld_hi_bits),
        .res_valid(res_valid), .res_class(res_class), .res_drop(res_drop)
    );

    always #5 clk = ~clk;

    int    checks = 0, fails = 0;
    string cur_req = "R12";

    // Behavioural reference state
    bit [35:0] prog [64];
    bit [15:0] mwin [64];
    bit [11:0] mlo;
    bit [31:0] mrf;
    int        mpc;
    bit        mact, mdone, ev, edrop;
    bit [7:0]  ecls;

    function automatic bit mop(int op, bit a, bit b);
        if (op == 1) return a & b;
        if (op == 2) return a | b;
        if (op == 3) return a ^ b;
        if (op == 4) return ~a;
        return a;
    endfunction

    function automatic void mset(int rd, bit v);
        if (rd != 0) mrf[rd] = v;
    endfunction

    // Runs one instruction on the model; returns 1 for terminate.
    function automatic bit mexec(bit [35:0] ins);
        int mode = int'(ins >> 34);
        int op   = int'(ins & 36'h7);
        int rd5  = int'((ins >> 3) & 36'h1f);
        int ra   = int'((ins >> 8) & 36'h1f);
        int rb   = int'((ins >> 13) & 36'h1f);
        int rc   = int'((ins >> 18) & 36'h1f);
        int op2  = int'((ins >> 23) & 36'h7);
        if (mode == 0) begin
            int        off = int'((ins >> 7) & 36'h3f);
            int        rd4 = int'((ins >> 3) & 36'hf);
            bit [15:0] w   = mwin[off];
            bit [15:0] m   = '0;
            bit        t;
            if (ins[33]) t = w[int'((ins >> 29) & 36'hf)];
            else begin
                for (int k = 0; k < 4; k++) if (ins[29+k]) m = m | (16'hF << (4*k));
                t = ((w & m) == 16'((ins >> 13) & 36'hffff));
            end
            mset(rd4, mop(op, t, mrf[rd4]));
        end else if (mode == 1) begin
            mset(rd5, mop(op, mrf[ra], mrf[rb]));
        end else if (mode == 2) begin
            mset(rd5, mop(op2, mop(op, mrf[ra], mrf[rb]), mrf[rc]));
        end else return 1'b1;
        return 1'b0;
    endfunction

    function automatic void model_step();
        ev = 1'b0;
        if (ld_hi_we && ld_commit) prog[ld_addr] = {ld_hi_bits, mlo};
        if (ld_lo_we) mlo = ld_lo_bits;
        if (word_valid) begin
            bit was_done;
            if (word_sof) begin
                mact = cfg_enable; mdone = 1'b0; mpc = 0; mrf = '0;
            end
            if (mact) begin
                was_done = mdone;
                if (!mdone && mpc < 64) begin
                    mwin[mpc] = word_data;
                    if (mexec(prog[mpc])) begin mdone = 1'b1; ev = 1'b1; end
                end
                mpc++;
                if (word_eof) begin
                    if (!was_done) ev = 1'b1;
                    mact = 1'b0;
                end
                if (ev) begin ecls = mrf[31:24]; edrop = mrf[23]; end
            end
        end
    endfunction

    task automatic compare();
        checks++;
        if (res_valid !== ev) begin
            fails++;
            $display("FAIL %s: res_valid=%0d expected %0d at %0t", cur_req, res_valid, ev, $time);
        end
        if (ev || cur_req == "R12") begin
            checks += 2;
            if (res_class !== ecls) begin
                fails++;
                $display("FAIL %s: res_class=%h expected %h at %0t", cur_req, res_class, ecls, $time);
            end
            if (res_drop !== edrop) begin
                fails++;
                $display("FAIL %s: res_drop=%0d expected %0d at %0t", cur_req, res_drop, edrop, $time);
            end
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    // Instruction encoders, field positions as in R3..R7
    function automatic bit [35:0] e_cmp(int off, int val, int m4, int op, int rd);
        return (36'(m4) << 29) | (36'(val) << 13) | (36'(off) << 7) | (36'(rd) << 3) | 36'(op);
    endfunction
    function automatic bit [35:0] e_bt(int off, int idx, int op, int rd);
        return (36'(1) << 33) | (36'(idx) << 29) | (36'(off) << 7) | (36'(rd) << 3) | 36'(op);
    endfunction
    function automatic bit [35:0] e_l2(int rd, int ra, int op, int rb);
        return (36'(1) << 34) | (36'(rb) << 13) | (36'(ra) << 8) | (36'(rd) << 3) | 36'(op);
    endfunction
    function automatic bit [35:0] e_l3(int rd, int ra, int op, int rb, int op2, int rc);
        return (36'(2) << 34) | (36'(op2) << 23) | (36'(rc) << 18) | (36'(rb) << 13)
             | (36'(ra) << 8) | (36'(rd) << 3) | 36'(op);
    endfunction
    function automatic bit [35:0] e_fin();
        return 36'(3) << 34;
    endfunction

    task automatic load(int addr, bit [35:0] ins, bit do_commit);
        ld_lo_we = 1'b1; ld_lo_bits = ins[11:0];
        cycle();
        ld_lo_we = 1'b0;
        ld_hi_we = 1'b1; ld_commit = do_commit; ld_addr = 6'(addr); ld_hi_bits = ins[35:12];
        cycle();
        ld_hi_we = 1'b0; ld_commit = 1'b0;
    endtask

    task automatic frame(int len, bit [15:0] w0, bit [15:0] w1, bit [15:0] w2,
                         bit [15:0] w10, int seed, bit gaps, bit with_eof);
        for (int i = 0; i < len; i++) begin
            word_valid = 1'b1;
            word_sof   = (i == 0);
            word_eof   = with_eof && (i == len - 1);
            case (i)
                0: word_data = w0;
                1: word_data = w1;
                2: word_data = w2;
                10: word_data = w10;
                default: word_data = 16'(i * 40503 + seed * 977);
            endcase
            cycle();
            word_valid = 1'b0; word_sof = 1'b0; word_eof = 1'b0;
            if (gaps && (i % 3 == 1)) cycle();
        end
        cycle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) prog[i] = '0;
        mlo = '0; mrf = '0; mpc = 0; mact = 0; mdone = 0; ev = 0; ecls = '0; edrop = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R12: reset outputs and all-no-op memory
        cur_req = "R12";
        compare();
        cycle();
        cfg_enable = 1'b1;
        frame(5, 16'hffff, 16'h1234, 16'h00a0, 16'h0, 1, 1'b0, 1'b1);

        // R10: load the main program
        cur_req = "R10";
        load(0,  e_cmp(0, 'hffff, 'hf, 0, 1), 1'b1);
        load(1,  e_cmp(1, 'h1234, 'hf, 1, 1), 1'b1);
        load(2,  e_bt(0, 3, 0, 2), 1'b1);
        load(3,  e_cmp(2, 'h00a0, 'h2, 0, 3), 1'b1);
        load(4,  e_l2(24, 1, 1, 2), 1'b1);
        load(5,  e_l2(25, 3, 4, 0), 1'b1);
        load(6,  e_l3(26, 1, 2, 3, 3, 2), 1'b1);
        load(7,  e_l2(23, 1, 4, 0), 1'b1);
        load(8,  e_l2(0, 1, 0, 0), 1'b1);
        load(9,  e_l2(31, 0, 4, 0), 1'b1);
        load(10, e_cmp(10, 'hbeef, 'hf, 0, 4), 1'b1);
        load(11, e_l2(27, 4, 0, 0), 1'b1);
        load(12, e_l3(28, 1, 3, 2, 2, 4), 1'b1);
        load(13, e_bt(1, 15, 3, 5), 1'b1);
        load(14, e_l2(29, 5, 2, 3), 1'b1);
        load(15, e_fin(), 1'b1);

        // R3: legality of the loaded program (no offset beyond its address)
        for (int a = 0; a < 64; a++) begin
            if (prog[a][35:34] == 2'd0) begin
                checks++;
                if (int'(prog[a][12:7]) > a) begin
                    fails++;
                    $display("FAIL R3: offset %0d expected at most %0d", prog[a][12:7], a);
                end
            end
        end

        // R1, R3, R4, R5, R6: several word patterns
        cur_req = "R1/R3/R4/R5/R6";
        frame(20, 16'hffff, 16'h1234, 16'h13a5, 16'hbeef, 2, 1'b0, 1'b1);
        frame(20, 16'hfff0, 16'h1234, 16'h0000, 16'h1111, 3, 1'b0, 1'b1);
        frame(20, 16'hffff, 16'h1235, 16'hffaf, 16'hbeef, 4, 1'b0, 1'b1);
        frame(20, 16'h0008, 16'h9234, 16'h00b0, 16'hbeee, 5, 1'b0, 1'b1);
        frame(18, 16'hffff, 16'h1234, 16'h77a7, 16'h0000, 6, 1'b0, 1'b1);
        for (int s = 0; s < 6; s++)
            frame(17, 16'(s * 4099), 16'(s * 777), 16'(s * 13), 16'hbeef, s, 1'b0, 1'b1);

        // R2: idle gaps inside frames, same-cycle compare of word 10
        cur_req = "R2";
        frame(20, 16'hffff, 16'h1234, 16'h00a0, 16'hbeef, 7, 1'b1, 1'b1);
        frame(20, 16'hffff, 16'h1234, 16'h00a0, 16'hbeed, 8, 1'b1, 1'b1);

        // R7: terminate before end, and terminate on the last word
        cur_req = "R7";
        frame(30, 16'hffff, 16'h1234, 16'h00a0, 16'hbeef, 9, 1'b0, 1'b1);
        frame(16, 16'hffff, 16'h9234, 16'h00a0, 16'hbeef, 10, 1'b0, 1'b1);

        // R8: frames that end before the terminate instruction
        cur_req = "R8";
        frame(6, 16'hffff, 16'h1234, 16'h00a0, 16'h0, 11, 1'b0, 1'b1);
        frame(12, 16'hffff, 16'h1234, 16'h00a0, 16'hbeef, 12, 1'b1, 1'b1);

        // R9: back-to-back frames and a restart in mid-frame
        cur_req = "R9";
        frame(20, 16'hffff, 16'h1234, 16'h00a0, 16'hbeef, 13, 1'b0, 1'b1);
        frame(1, 16'h0000, 16'h0, 16'h0, 16'h0, 14, 1'b0, 1'b1);
        frame(8, 16'hffff, 16'h1234, 16'h00a0, 16'h0, 15, 1'b0, 1'b0);
        frame(5, 16'h1111, 16'h1234, 16'h00a0, 16'h0, 16, 1'b0, 1'b1);

        // R11: disabled start, and words outside a frame
        cur_req = "R11";
        cfg_enable = 1'b0;
        frame(20, 16'hffff, 16'h1234, 16'h00a0, 16'hbeef, 17, 1'b0, 1'b1);
        cfg_enable = 1'b1;
        word_valid = 1'b1; word_eof = 1'b1; word_data = 16'hffff;
        cycle();
        word_valid = 1'b0; word_eof = 1'b0;
        cycle();

        // R10: high write without commit, then a committed change
        cur_req = "R10";
        load(4, e_l2(24, 0, 4, 0), 1'b0);
        frame(20, 16'hfff0, 16'h1234, 16'h00a0, 16'hbeef, 18, 1'b0, 1'b1);
        load(5, e_l2(25, 3, 0, 0), 1'b1);
        frame(20, 16'hffff, 16'h1234, 16'h00a0, 16'hbeef, 19, 1'b0, 1'b1);

        // R8: no terminate at all, frame longer than the memory
        cur_req = "R8";
        load(15, 36'h0, 1'b1);
        frame(70, 16'hffff, 16'h1234, 16'h00a0, 16'hbeef, 20, 1'b0, 1'b1);
        frame(3, 16'hffff, 16'h1234, 16'h00a0, 16'h0, 21, 1'b0, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule